// File: doc/BRIEF.md
# Vector Mask Unit

This unit keeps the 64-bit predicate mask of a vector engine and runs the operations that build it and use it. A compare sequence takes element pairs one per clock and sets one mask bit per element. The pair is either two vector operands or a vector operand against a scalar captured at the start, and the test is either equality or inequality. The new mask replaces the old one only when the last of the vector-length elements arrives. A clear command sets every bit to one.

The unit always presents the population count of the mask, so software can load it into a length register. It also presents a per-element enable, selected by an element index, that the arithmetic lanes use to gate their result writeback. Masked elements still take their clock in those lanes; the enable only suppresses the write. An index-generation sequence walks the mask from bit 0 upward. For each set bit it emits that bit position times a stride, giving a dense index vector for gather and scatter, and it ends with a one-cycle done flag.

Top module: `vmask_unit`

## Requirements
- R1: After reset the mask is all ones, the count reads 64, and busy, idxValid and idxDone are 0.
- R2: When idle, clearMask sets all 64 mask bits to one at the next edge and takes priority over cmpStart and idxStart in the same cycle.
- R3: A compare started with cmpNotEq=0 writes mask bit i as 1 when elemA equals elemB for the i-th accepted element; with cmpNotEq=1 the bit is the inverse. Only cycles with elemValid=1 accept an element, in order from bit 0.
- R4: With cmpUseScalar=1 the compare uses the cmpScalar value captured at cmpStart in place of elemB.
- R5: The mask keeps its old value during a compare and takes the new value at the edge that accepts element VL-1. Bits at and above VL are 0. cmpVecLen=0 sets the mask to all zeros at the start edge, and values above 64 act as 64.
- R6: maskCount always equals the number of 1 bits in the mask.
- R7: elemEnable equals mask bit elemSel.
- R8: After idxStart in idle, the following cycles show idxValid=1 once per set mask bit, in ascending bit order, with idxData = position × stride. The stride is taken from idxStride at the start. Then idxDone is 1 for exactly one cycle, idxValid and idxDone are never 1 together, and the unit returns to idle.
- R9: busy is 1 while a compare or index sequence runs; clearMask, cmpStart and idxStart given while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearMask | input | 1 | Set every mask bit to one (idle only) |
| cmpStart | input | 1 | Begin a compare sequence (idle only) |
| cmpVecLen | input | 7 | Element count of the compare, clamped to 64 |
| cmpNotEq | input | 1 | 1 selects not-equal, 0 selects equal |
| cmpUseScalar | input | 1 | 1 compares against the captured scalar |
| cmpScalar | input | 64 | Scalar operand, captured at cmpStart |
| elemValid | input | 1 | An element pair is present this cycle |
| elemA | input | 64 | First operand element |
| elemB | input | 64 | Second operand element |
| idxStart | input | 1 | Begin compressed index generation (idle only) |
| idxStride | input | 8 | Multiplier applied to each set position |
| elemSel | input | 6 | Element whose enable is requested |
| elemEnable | output | 1 | Writeback enable for element elemSel |
| maskOut | output | 64 | Current committed mask |
| maskCount | output | 7 | Number of ones in the mask |
| idxValid | output | 1 | idxData holds an index entry |
| idxData | output | 14 | Position of a set bit times the stride |
| idxDone | output | 1 | One-cycle flag after the last entry |
| busy | output | 1 | A sequence is in progress |

## Verification
A wrong element counter or a mis-captured operand mode shows up at maskOut and maskCount at the commit edge of the same compare. A wrong bit in the mask register also reaches elemEnable as soon as that element is selected. A corrupted pending copy during index generation surfaces in the very next idxData value, or as idxDone arriving a cycle early or late. Comparing every output against a behavioural model on each clock exposes any such fault within one cycle of its first visible effect.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  localparam int MASK_LEN = 64;
  localparam int POS_W    = $clog2(MASK_LEN);
  localparam int CNT_W    = POS_W + 1;

  // Strobes issued by the sequencer to the mask datapath
  typedef struct packed {
    logic             setAllOnes;
    logic             zeroMask;
    logic             beginCmp;
    logic             captureBit;
    logic             commitMask;
    logic             beginIdx;
    logic             stepIdx;
    logic [POS_W-1:0] bitPos;
  } vmStrobe_t;
endpackage

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
  import vmask_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearMask,
  input  logic             cmpStart,
  input  logic [CNT_W-1:0] cmpVecLen,
  input  logic             elemValid,
  input  logic             idxStart,
  input  logic             pendEmpty,
  output vmStrobe_t        strb,
  output logic             busy,
  output logic             idxPhase
);
  typedef enum logic [1:0] {S_IDLE, S_CMP, S_IDX} state_t;

  state_t           state, stateNext;
  logic [CNT_W-1:0] vlReg, elemCnt, vlClamp;
  logic             lastElem;

  assign vlClamp  = (cmpVecLen > CNT_W'(MASK_LEN)) ? CNT_W'(MASK_LEN) : cmpVecLen;
  assign lastElem = (elemCnt + 1'b1) == vlReg;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (clearMask) begin
          strb.setAllOnes = 1'b1;
        end else if (cmpStart) begin
          if (vlClamp == '0) begin
            strb.zeroMask = 1'b1;
          end else begin
            strb.beginCmp = 1'b1;
            stateNext     = S_CMP;
          end
        end else if (idxStart) begin
          strb.beginIdx = 1'b1;
          stateNext     = S_IDX;
        end
      end
      S_CMP: begin
        strb.bitPos     = elemCnt[POS_W-1:0];
        strb.captureBit = elemValid;
        strb.commitMask = elemValid && lastElem;
        if (elemValid && lastElem) stateNext = S_IDLE;
      end
      S_IDX: begin
        strb.stepIdx = !pendEmpty;
        if (pendEmpty) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      vlReg   <= '0;
      elemCnt <= '0;
    end else begin
      state <= stateNext;
      if (strb.beginCmp) begin
        vlReg   <= vlClamp;
        elemCnt <= '0;
      end else if (strb.captureBit) begin
        elemCnt <= elemCnt + 1'b1;
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign idxPhase = (state == S_IDX);
endmodule

// File: rtl/vmask_dp.sv
module vmask_dp
  import vmask_pkg::*;
#(
  parameter int ELEM_W   = 64,
  parameter int STRIDE_W = 8,
  localparam int IDX_W   = POS_W + STRIDE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  vmStrobe_t           strb,
  input  logic                idxPhase,
  input  logic                cmpNotEq,
  input  logic                cmpUseScalar,
  input  logic [ELEM_W-1:0]   cmpScalar,
  input  logic [ELEM_W-1:0]   elemA,
  input  logic [ELEM_W-1:0]   elemB,
  input  logic [STRIDE_W-1:0] idxStride,
  input  logic [POS_W-1:0]    elemSel,
  output logic                pendEmpty,
  output logic                elemEnable,
  output logic [MASK_LEN-1:0] maskOut,
  output logic [CNT_W-1:0]    maskCount,
  output logic                idxValid,
  output logic [IDX_W-1:0]    idxData,
  output logic                idxDone
);
  logic [MASK_LEN-1:0] maskReg, shadow, shadowNext, pending;
  logic [ELEM_W-1:0]   scalarReg, rhs;
  logic [STRIDE_W-1:0] strideReg;
  logic                neReg, useScalarReg, cmpHit;
  logic [POS_W-1:0]    lowPos;

  assign rhs        = useScalarReg ? scalarReg : elemB;
  assign cmpHit     = (elemA == rhs) ^ neReg;
  assign shadowNext = shadow | (MASK_LEN'(cmpHit) << strb.bitPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg      <= '1;
      shadow       <= '0;
      pending      <= '0;
      scalarReg    <= '0;
      strideReg    <= '0;
      neReg        <= 1'b0;
      useScalarReg <= 1'b0;
    end else begin
      if (strb.setAllOnes)      maskReg <= '1;
      else if (strb.zeroMask)   maskReg <= '0;
      else if (strb.commitMask) maskReg <= shadowNext;

      if (strb.beginCmp) begin
        shadow       <= '0;
        neReg        <= cmpNotEq;
        useScalarReg <= cmpUseScalar;
        scalarReg    <= cmpScalar;
      end else if (strb.captureBit) begin
        shadow <= shadowNext;
      end

      if (strb.beginIdx) begin
        pending   <= maskReg;
        strideReg <= idxStride;
      end else if (strb.stepIdx) begin
        pending <= pending & (pending - 1'b1);
      end
    end
  end

  // lowest set position of the pending copy
  always_comb begin
    lowPos = '0;
    for (int i = MASK_LEN - 1; i >= 0; i--) begin
      if (pending[i]) lowPos = POS_W'(i);
    end
  end

  // population count of the committed mask
  always_comb begin
    maskCount = '0;
    for (int i = 0; i < MASK_LEN; i++) begin
      maskCount = maskCount + CNT_W'(maskReg[i]);
    end
  end

  assign pendEmpty  = (pending == '0);
  assign idxValid   = idxPhase && !pendEmpty;
  assign idxDone    = idxPhase && pendEmpty;
  assign idxData    = IDX_W'(lowPos) * IDX_W'(strideReg);
  assign elemEnable = maskReg[elemSel];
  assign maskOut    = maskReg;
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int ELEM_W   = 64,
  parameter int STRIDE_W = 8,
  localparam int IDX_W   = POS_W + STRIDE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearMask,
  input  logic                cmpStart,
  input  logic [CNT_W-1:0]    cmpVecLen,
  input  logic                cmpNotEq,
  input  logic                cmpUseScalar,
  input  logic [ELEM_W-1:0]   cmpScalar,
  input  logic                elemValid,
  input  logic [ELEM_W-1:0]   elemA,
  input  logic [ELEM_W-1:0]   elemB,
  input  logic                idxStart,
  input  logic [STRIDE_W-1:0] idxStride,
  input  logic [POS_W-1:0]    elemSel,
  output logic                elemEnable,
  output logic [MASK_LEN-1:0] maskOut,
  output logic [CNT_W-1:0]    maskCount,
  output logic                idxValid,
  output logic [IDX_W-1:0]    idxData,
  output logic                idxDone,
  output logic                busy
);
  vmStrobe_t strb;
  logic      pendEmpty, idxPhase;

  vmask_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .clearMask(clearMask), .cmpStart(cmpStart),
    .cmpVecLen(cmpVecLen), .elemValid(elemValid), .idxStart(idxStart),
    .pendEmpty(pendEmpty), .strb(strb), .busy(busy), .idxPhase(idxPhase)
  );

  vmask_dp #(.ELEM_W(ELEM_W), .STRIDE_W(STRIDE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idxPhase(idxPhase),
    .cmpNotEq(cmpNotEq), .cmpUseScalar(cmpUseScalar), .cmpScalar(cmpScalar),
    .elemA(elemA), .elemB(elemB), .idxStride(idxStride), .elemSel(elemSel),
    .pendEmpty(pendEmpty), .elemEnable(elemEnable), .maskOut(maskOut),
    .maskCount(maskCount), .idxValid(idxValid), .idxData(idxData),
    .idxDone(idxDone)
  );
endmodule

// File: rtl/vmask_checker.sv
module vmask_checker
  import vmask_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                clearMask,
  input logic                busy,
  input logic [MASK_LEN-1:0] maskOut,
  input logic [CNT_W-1:0]    maskCount,
  input logic                idxValid,
  input logic [IDX_W-1:0]    idxData,
  input logic                idxDone
);
  a_r2_clear_sets_ones: assert property (@(posedge clk) disable iff (!rstN)
    (clearMask && !busy) |=> (maskOut == '1));

  a_r6_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    maskCount == CNT_W'($countones(maskOut)));

  a_r8_valid_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(idxValid && idxDone));

  a_r8_done_returns_idle: assert property (@(posedge clk) disable iff (!rstN)
    idxDone |=> (!busy && !idxDone));

  a_r9_mask_held_in_index: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |=> $stable(maskOut));

  a_r9_index_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid || idxDone) |-> busy);
endmodule

bind vmask_unit vmask_checker #(.IDX_W(IDX_W)) i_vmask_checker (
  .clk(clk), .rstN(rstN), .clearMask(clearMask), .busy(busy),
  .maskOut(maskOut), .maskCount(maskCount), .idxValid(idxValid),
  .idxData(idxData), .idxDone(idxDone)
);

// File: tb/test_vmask_unit.sv
`timescale 1ns/1ps
module test_vmask_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearMask = 0, cmpStart = 0, cmpNotEq = 0, cmpUseScalar = 0;
  logic [6:0]  cmpVecLen = 0;
  logic [63:0] cmpScalar = 0, elemA = 0, elemB = 0;
  logic        elemValid = 0, idxStart = 0;
  logic [7:0]  idxStride = 0;
  logic [5:0]  elemSel = 0;
  logic        elemEnable, idxValid, idxDone, busy;
  logic [63:0] maskOut;
  logic [6:0]  maskCount;
  logic [13:0] idxData;

  always #5 clk = ~clk;

  vmask_unit i_vmask_unit (
    .clk(clk), .rstN(rstN), .clearMask(clearMask), .cmpStart(cmpStart),
    .cmpVecLen(cmpVecLen), .cmpNotEq(cmpNotEq), .cmpUseScalar(cmpUseScalar),
    .cmpScalar(cmpScalar), .elemValid(elemValid), .elemA(elemA), .elemB(elemB),
    .idxStart(idxStart), .idxStride(idxStride), .elemSel(elemSel),
    .elemEnable(elemEnable), .maskOut(maskOut), .maskCount(maskCount),
    .idxValid(idxValid), .idxData(idxData), .idxDone(idxDone), .busy(busy)
  );

  int    vectors = 0, miscompares = 0, cycles = 0;
  string phase = "R1";

  // behavioural reference
  logic [63:0] refMask, refShadow, refScal;
  int          refMode, refVl, refCnt;
  bit          refNe, refUsc;
  int          idxQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      refMask = '1; refMode = 0; idxQ.delete();
    end else begin
      case (refMode)
        0: begin
          if (clearMask) refMask = '1;
          else if (cmpStart) begin
            int v;
            v = (cmpVecLen > 64) ? 64 : int'(cmpVecLen);
            if (v == 0) refMask = '0;
            else begin
              refMode = 1; refVl = v; refCnt = 0; refShadow = '0;
              refNe = cmpNotEq; refUsc = cmpUseScalar; refScal = cmpScalar;
            end
          end else if (idxStart) begin
            idxQ.delete();
            for (int i = 0; i < 64; i++) if (refMask[i]) idxQ.push_back(i * int'(idxStride));
            refMode = 2;
          end
        end
        1: if (elemValid) begin
          refShadow[refCnt] = (elemA == (refUsc ? refScal : elemB)) ^ refNe;
          refCnt++;
          if (refCnt == refVl) begin refMask = refShadow; refMode = 0; end
        end
        default: if (idxQ.size() > 0) void'(idxQ.pop_front()); else refMode = 0;
      endcase
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic checkAll();
    bit expValid, expDone;
    expValid = (refMode == 2) && (idxQ.size() > 0);
    expDone  = (refMode == 2) && (idxQ.size() == 0);
    chk("maskOut", maskOut, refMask);
    chk("maskCount", 64'(maskCount), 64'($countones(refMask)));
    chk("elemEnable", 64'(elemEnable), 64'(refMask[elemSel]));
    chk("busy", 64'(busy), 64'(refMode != 0));
    chk("idxValid", 64'(idxValid), 64'(expValid));
    chk("idxDone", 64'(idxDone), 64'(expDone));
    if (expValid) chk("idxData", 64'(idxData), 64'(idxQ[0]));
  endtask

  task automatic tick();
    @(posedge clk); #1; checkAll();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  function automatic void pairFor(int kind, int i, output logic [63:0] a, output logic [63:0] b);
    case (kind)
      0: begin a = 64'(i) * 64'h1001_0000_1001; b = (i % 3 == 0) ? a : a ^ 64'h1; end
      1: begin a = (i % 2 != 0) ? 64'h5 : 64'h7; b = 64'hDEAD_BEEF; end
      default: begin a = 64'(i); b = (i % 5 == 2) ? 64'(i) : ~64'(i); end
    endcase
  endfunction

  task automatic runCmp(int len, bit ne, bit usc, logic [63:0] scal, int kind, int gap, bit poke);
    int n;
    n = (len > 64) ? 64 : len;
    cmpStart = 1; cmpVecLen = 7'(len); cmpNotEq = ne; cmpUseScalar = usc; cmpScalar = scal;
    tick();
    cmpStart = 0; cmpScalar = 64'h0BAD;  // later changes must not matter (R4)
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, b;
      if (gap > 0 && i % gap == 1) begin elemValid = 0; elemA = '1; tick(); end
      pairFor(kind, i, a, b);
      elemValid = 1; elemA = a; elemB = b;
      if (poke && i == 3) begin clearMask = 1; cmpStart = 1; idxStart = 1; end  // R9
      tick();
      clearMask = 0; cmpStart = 0; idxStart = 0;
    end
    elemValid = 0;
    tick();
  endtask

  task automatic runIdx(logic [7:0] stride, bit poke);
    idxStart = 1; idxStride = stride;
    tick();
    idxStart = 0; idxStride = 8'hFF;
    if (poke) begin clearMask = 1; cmpStart = 1; cmpVecLen = 0; tick(); clearMask = 0; cmpStart = 0; end  // R9
    for (int k = 0; k < 80 && refMode != 0; k++) tick();
    tick();
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick(); tick();

    phase = "R3"; runCmp(64, 0, 0, 0, 0, 0, 0);
    phase = "R7"; for (int s = 0; s < 64; s++) begin elemSel = 6'(s); tick(); end
    phase = "R8"; runIdx(8, 0);
    phase = "R3"; runCmp(10, 1, 0, 0, 2, 0, 0);
    phase = "R2"; clearMask = 1; cmpStart = 1; cmpVecLen = 5; idxStart = 1; tick();
    clearMask = 0; cmpStart = 0; idxStart = 0; tick();
    phase = "R4"; runCmp(20, 1, 1, 64'h7, 1, 0, 0);
    phase = "R8"; runIdx(3, 0);
    phase = "R5"; runCmp(37, 0, 0, 0, 2, 4, 0);
    phase = "R6"; elemSel = 36; tick(); elemSel = 37; tick();
    phase = "R5"; runCmp(100, 0, 0, 0, 0, 0, 0);
    phase = "R9"; runCmp(12, 1, 0, 0, 0, 0, 1);
    phase = "R9"; runIdx(5, 1);
    phase = "R5"; runCmp(0, 0, 0, 0, 0, 0, 0);
    phase = "R8"; runIdx(4, 0);
    phase = "R2"; clearMask = 1; tick(); clearMask = 0; tick();
    phase = "R8"; runIdx(1, 0);
    report();
  end
endmodule